// File: doc/BRIEF.md
# Periodic Prescaler Timer Interrupt

The block is the first interval timer of a small 4-bit microcontroller core. A divider turns the input clock into machine-cycle ticks, one every 6 clocks. A 7-bit prescaler counts those ticks, so a full interval is 768 input clocks. At the end of each interval the block sets an interrupt request flag and starts the next interval at once. The timer starts counting as soon as reset is released. Nothing has to start it.

The core writes a 4-bit control register. Bit 0 of that register gates the interrupt request. The other three bits are kept and read back, but they have no effect on the timer. The interrupt acknowledge drives a one-cycle pulse that clears the flag. The block also registers the level on the external T input pin. It raises a one-cycle re-check pulse after any control write or any interval wrap, which tells the core to look at the pending-interrupt condition again.

Top module: `tmr1_irq_top`

## Requirements
- R1: While rst_ni is low, flag_o, irq_o, recheck_o, t_state_o and ctrl_o are all 0.
- R2: With no control write at all, flag_o first reads 1 after exactly 768 rising clock edges counted from reset release. Before that edge it reads 0.
- R3: The interval restarts on its own. flag_o is set again after every further 768 edges (edges 1536, 2304, ...), whatever the control register holds.
- R4: A flag_clr_i high for one cycle clears flag_o after the next edge. If that same edge also ends an interval, flag_o reads 1.
- R5: irq_o equals flag_o AND ctrl_o[0]. ctrl_o holds the last value written through ctrl_we_i/ctrl_wdata_i. Bits 1 to 3 of that value never change irq_o or the timing of flag_o.
- R6: recheck_o is 1 for the cycle that follows an edge at which ctrl_we_i was high or an interval ended. Otherwise it is 0.
- R7: t_state_o equals the value t_pin_i had at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 4 | Control write data; bit 0 enables the interrupt |
| flag_clr_i | input | 1 | One-cycle flag clear from the interrupt acknowledge |
| t_pin_i | input | 1 | External T pin level |
| t_state_o | output | 1 | Registered T pin state |
| ctrl_o | output | 4 | Control register contents |
| flag_o | output | 1 | Timer interrupt request flag |
| irq_o | output | 1 | Gated interrupt request |
| recheck_o | output | 1 | Pulse telling the core to re-evaluate the pending interrupt |

## Verification
An interval wrap can fall in the same cycle as an acknowledge clear, and it can also fall in the same cycle as a control write. The bench drives flag_clr_i in the cycle just before the edge at 1536 and checks that the flag survives. It also issues a control write just before the edge at 2304 and checks that recheck_o still shows a single pulse and that the enable changes in step. Every cycle is judged against a reference model in the bench, which is keyed only to the count of edges since reset.

// File: rtl/tmr1_pkg.sv
package tmr1_pkg;
  parameter int unsigned CTRL_W     = 4;
  parameter int unsigned IRQ_EN_BIT = 0;
  typedef logic [CTRL_W-1:0] ctrl_t;
endpackage

// File: rtl/tmr1_cyc_div.sv
module tmr1_cyc_div #(
  parameter int unsigned CYC_CLKS = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_CLKS - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr1_prescaler.sv
module tmr1_prescaler #(
  parameter int unsigned PRE_BITS = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic wrap_o
);
  logic [PRE_BITS-1:0] pre_q;

  // wraps to zero on its own: next interval starts immediately
  assign wrap_o = tick_i && (&pre_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (tick_i) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr1_irq_ctrl.sv
module tmr1_irq_ctrl
  import tmr1_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wrap_i,
  input  logic  ctrl_we_i,
  input  ctrl_t ctrl_wdata_i,
  input  logic  flag_clr_i,
  output ctrl_t ctrl_o,
  output logic  flag_o,
  output logic  irq_o,
  output logic  recheck_o
);
  ctrl_t ctrl_q;
  logic  flag_q;
  logic  recheck_q;

  for (genvar i = 0; i < CTRL_W; i++) begin : g_ctrl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        ctrl_q[i] <= 1'b0;
      else if (ctrl_we_i) ctrl_q[i] <= ctrl_wdata_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q    <= 1'b0;
      recheck_q <= 1'b0;
    end else begin
      flag_q    <= wrap_i | (flag_q & ~flag_clr_i); // set beats clear
      recheck_q <= wrap_i | ctrl_we_i;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign flag_o    = flag_q;
  assign irq_o     = flag_q & ctrl_q[IRQ_EN_BIT];
  assign recheck_o = recheck_q;
endmodule

// File: rtl/tmr1_irq_top.sv
module tmr1_irq_top
  import tmr1_pkg::*;
#(
  parameter int unsigned CYC_CLKS = 6,
  parameter int unsigned PRE_BITS = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              flag_clr_i,
  input  logic              t_pin_i,
  output logic              t_state_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic              recheck_o
);
  logic tick;
  logic wrap;
  logic t_q;

  tmr1_cyc_div #(.CYC_CLKS(CYC_CLKS)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  tmr1_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .wrap_o(wrap)
  );

  tmr1_irq_ctrl u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .wrap_i(wrap),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
    .flag_clr_i(flag_clr_i), .ctrl_o(ctrl_o), .flag_o(flag_o),
    .irq_o(irq_o), .recheck_o(recheck_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) t_q <= 1'b0;
    else         t_q <= t_pin_i;
  end

  assign t_state_o = t_q;
endmodule

// File: rtl/tmr1_irq_chk.sv
module tmr1_irq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wrap,
  input logic ctrl_we_i,
  input logic flag_clr_i,
  input logic t_pin_i,
  input logic t_state_o,
  input logic flag_o,
  input logic irq_o,
  input logic recheck_o
);
  assert_wrap_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> flag_o);
  assert_clr_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !wrap) |=> !flag_o);
  assert_irq_needs_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);
  assert_write_recheck_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i || wrap) |=> recheck_o);
  assert_quiet_recheck_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_we_i && !wrap) |=> !recheck_o);
  assert_t_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 t_state_o == $past(t_pin_i));
endmodule

bind tmr1_irq_top tmr1_irq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wrap(wrap), .ctrl_we_i(ctrl_we_i),
  .flag_clr_i(flag_clr_i), .t_pin_i(t_pin_i), .t_state_o(t_state_o),
  .flag_o(flag_o), .irq_o(irq_o), .recheck_o(recheck_o)
);

// File: tb/sim_tmr1_irq_top.sv
`timescale 1ns/1ps
module sim_tmr1_irq_top;
  localparam int PERIOD = 6 * 128;
  localparam int LAST_N = 4 * PERIOD + 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] wdata = 4'h0;
  logic       clr = 1'b0;
  logic       tpin = 1'b0;
  logic       t_state, flag, irq, recheck;
  logic [3:0] ctrl;

  int n_cmp = 0, n_bad = 0, n_edge = 0;
  logic e_flag = 1'b0, e_rchk = 1'b0, e_t = 1'b0;
  logic [3:0] e_ctrl = 4'h0;

  always #4 clk = ~clk;

  tmr1_irq_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(we), .ctrl_wdata_i(wdata),
    .flag_clr_i(clr), .t_pin_i(tpin), .t_state_o(t_state), .ctrl_o(ctrl),
    .flag_o(flag), .irq_o(irq), .recheck_o(recheck)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s edge=%0d act=%h exp=%h", tag, n_edge, act, exp);
    end
  endtask

  task automatic step();
    logic wrap;
    @(posedge clk);
    n_edge++;
    wrap = (n_edge % PERIOD) == 0;
    e_flag = wrap | (e_flag & ~clr);
    e_rchk = wrap | we;
    if (we) e_ctrl = wdata;
    e_t = tpin;
    #2;
    chk(n_edge <= PERIOD ? "R2 flag" : (clr ? "R4 flag" : "R3 flag"), {3'b0, flag}, {3'b0, e_flag});
    chk("R5 ctrl", ctrl, e_ctrl);
    chk("R5 irq", {3'b0, irq}, {3'b0, e_flag & e_ctrl[0]});
    chk("R6 recheck", {3'b0, recheck}, {3'b0, e_rchk});
    chk("R7 t_state", {3'b0, t_state}, {3'b0, e_t});
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog edge=%0d act=hung exp=done", n_edge);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 flag", {3'b0, flag}, 4'h0);
    chk("R1 irq", {3'b0, irq}, 4'h0);
    chk("R1 recheck", {3'b0, recheck}, 4'h0);
    chk("R1 t_state", {3'b0, t_state}, 4'h0);
    chk("R1 ctrl", ctrl, 4'h0);
    @(negedge clk);
    rst_n = 1'b1;
    while (n_edge < LAST_N) begin
      step();
      // drives held until the next edge
      we = 1'b0; clr = 1'b0;
      tpin = n_edge[3] ^ n_edge[6];
      case (n_edge)
        100:  begin we = 1'b1; wdata = 4'b1110; end // R5 upper bits, no enable
        800:  begin we = 1'b1; wdata = 4'b0001; end
        850:  begin we = 1'b1; wdata = 4'b1111; end
        870:  begin we = 1'b1; wdata = 4'b1110; end
        880:  begin we = 1'b1; wdata = 4'b0001; end
        900:  clr = 1'b1;                           // R4 plain clear
        1535: clr = 1'b1;                           // R4 set wins
        1600: clr = 1'b1;
        2303: begin we = 1'b1; wdata = 4'b1000; end // R6 write on wrap
        2400: begin we = 1'b1; wdata = 4'b0101; end
        2401: begin we = 1'b1; wdata = 4'b0011; end
        2500: clr = 1'b1;
        default: ;
      endcase
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule